// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block keeps every in-flight memory operation of an out-of-order core in a small pool of slots and tells the issue logic which of them may execute now without breaking a relaxed consistency model. Dispatch hands over one operation per cycle. Each operation is a load, a store, or one of three barrier kinds, and it carries a may-alias hint. The block returns the slot index it used. The issue side watches a per-slot ready vector. When an operation has executed, the issue side sends back its slot index, and that slot is released.

Age is kept in a per-slot matrix of older-than bits. A slot never moves. Each slot runs a three-state machine. **FREE** moves to **WAIT** on *allocate*. **WAIT** moves to **READY** on *clear* (no older slot holds it back). **READY** moves to **FREE** on *execute* (a notification for that slot) or on *barrier-done* (a barrier always leaves READY after one cycle). A barrier only reaches READY when it is the oldest occupant. Dispatch stalls on three flags: one for no free slot, one for the load limit and one for the store limit.

Top module: `mem_order_queue`

## Requirements
- R1: Kind codes are 0 load, 1 store, 2 load barrier, 3 store barrier, 4 full barrier. After reset every slot is FREE, `ready_o` is 0, all full flags are 0 and `alloc_slot_o` is 0. `alloc_slot_o` always shows the lowest-numbered FREE slot (0 when none), and an accepted operation occupies that slot at the clock edge.
- R2: An accepted operation sits in WAIT for at least the cycle after its allocation edge. Its ready bit rises at the first later edge at which nothing older holds it back.
- R3: A load is held by an older load only while a store or a barrier of any kind, older than the load and younger than that older load, is still occupying a slot.
- R4: A load is held by an older store only when `no_alias_i` is 0 and either of the two may-alias bits is 1. Changing `no_alias_i` takes effect for waiting loads at the next edge.
- R5: A store is held by every older load, store, store barrier and full barrier, whatever `no_alias_i` says.
- R6: A barrier becomes ready only when no older slot is occupied. It returns to FREE at the following edge by itself, and no notification is needed.
- R7: A load barrier holds younger loads but not younger stores. A store barrier holds younger stores but not younger loads. A full barrier holds both.
- R8: An execute notification for a READY slot frees it at that edge. The slot can be allocated from the next cycle on. A notification for a WAIT or FREE slot has no effect.
- R9: `full_o` is 1 while every slot is occupied, and an allocation request in that state is dropped.
- R10: At most LD_CAP loads and ST_CAP stores may be in flight. A value of 0 (or above DEPTH) means DEPTH. `load_full_o` and `store_full_o` show that the limit has been reached, and a request of that kind is then dropped.
- R11: An allocation request with kind code 5, 6 or 7 is dropped and occupies nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| no_alias_i | input | 1 | 1: loads never wait for older stores |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_kind_i | input | 3 | Operation kind code |
| alloc_alias_i | input | 1 | May-alias hint of the new operation |
| exec_valid_i | input | 1 | Execute notification |
| exec_slot_i | input | $clog2(DEPTH) | Slot named by the notification |
| alloc_slot_o | output | $clog2(DEPTH) | Slot the next accepted operation takes |
| ready_o | output | DEPTH | Per-slot permission to execute |
| full_o | output | 1 | No free slot |
| load_full_o | output | 1 | Load limit reached |
| store_full_o | output | 1 | Store limit reached |

## Verification
Assertions cover the local slot rules on every cycle. An allocation only ever lands on a FREE slot. A blocked WAIT slot stays in WAIT. A READY barrier has no occupied older slot and is gone one edge later. An executed READY slot becomes FREE, and the load count never exceeds its limit. The pairwise ordering outcomes can only be shown by the bench's scenarios. This covers loads separated by a store, the alias setting flipped while a load waits, each barrier kind against each operation kind, and the one-cycle delay before a freed slot is reused. The bench runs a reference model of ages and slot states alongside the design in every cycle.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LBAR  = 3'd2,
        OP_SBAR  = 3'd3,
        OP_FBAR  = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    function automatic logic op_is_barrier(logic [2:0] k);
        return (k == OP_LBAR) || (k == OP_SBAR) || (k == OP_FBAR);
    endfunction

    function automatic logic op_kind_legal(logic [2:0] k);
        return k <= OP_FBAR;
    endfunction

endpackage

// File: rtl/mem_order_alloc.sv
module mem_order_alloc
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned LD_CAP = 0,
    parameter int unsigned ST_CAP = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DEPTH-1:0]           busy,
    input  logic [DEPTH-1:0][2:0]      kinds,
    input  logic                       alloc_valid,
    input  logic [2:0]                 alloc_kind,
    output logic [$clog2(DEPTH)-1:0]   alloc_slot,
    output logic [DEPTH-1:0]           alloc_onehot,
    output logic                       full,
    output logic                       load_full,
    output logic                       store_full
);
    localparam int unsigned SLOT_W = $clog2(DEPTH);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned LD_EFF = (LD_CAP == 0 || LD_CAP > DEPTH) ? DEPTH : LD_CAP;
    localparam int unsigned ST_EFF = (ST_CAP == 0 || ST_CAP > DEPTH) ? DEPTH : ST_CAP;

    logic [CNT_W-1:0] ld_cnt, st_cnt;
    logic             cap_ok, accept;

    always_comb begin
        alloc_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_slot = SLOT_W'(i);
        end
    end

    always_comb begin
        ld_cnt = '0;
        st_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ld_cnt = ld_cnt + CNT_W'(busy[i] && kinds[i] == OP_LOAD);
            st_cnt = st_cnt + CNT_W'(busy[i] && kinds[i] == OP_STORE);
        end
    end

    assign full       = &busy;
    assign load_full  = (ld_cnt >= CNT_W'(LD_EFF));
    assign store_full = (st_cnt >= CNT_W'(ST_EFF));

    always_comb begin
        case (alloc_kind)
            OP_LOAD:  cap_ok = !load_full;
            OP_STORE: cap_ok = !store_full;
            default:  cap_ok = 1'b1;
        endcase
    end

    assign accept       = alloc_valid && !full && op_kind_legal(alloc_kind) && cap_ok;
    assign alloc_onehot = accept ? (DEPTH'(1) << alloc_slot) : '0;

    AST_LOAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt <= CNT_W'(LD_EFF)) else $error("load limit exceeded"); // R10
    AST_STORE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt <= CNT_W'(ST_EFF)) else $error("store limit exceeded"); // R10
endmodule

// File: rtl/mem_order_hazard.sv
module mem_order_hazard
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic [DEPTH-1:0]            busy,
    input  logic [DEPTH-1:0][2:0]       kinds,
    input  logic [DEPTH-1:0]            alias_hint,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    input  logic                        no_alias,
    output logic [DEPTH-1:0]            blocked
);
    // sep[i][j]: an occupied non-load slot is younger than j and older than i
    logic [DEPTH-1:0][DEPTH-1:0] sep;

    function automatic logic pair_holds(logic [2:0] yk, logic [2:0] ok,
                                        logic ya, logic oa, logic na, logic between);
        logic r;
        case (yk)
            OP_LOAD: begin
                case (ok)
                    OP_LOAD:  r = between;
                    OP_STORE: r = !na && (ya || oa);
                    OP_SBAR:  r = 1'b0;
                    default:  r = 1'b1;
                endcase
            end
            OP_STORE: r = (ok != OP_LBAR);
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

    always_comb begin
        sep = '0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < DEPTH; j++)
                for (int k = 0; k < DEPTH; k++)
                    if (busy[k] && older[i][k] && older[k][j] && kinds[k] != OP_LOAD)
                        sep[i][j] = 1'b1;
    end

    always_comb begin
        blocked = '0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < DEPTH; j++)
                if (busy[j] && older[i][j] &&
                    pair_holds(kinds[i], kinds[j], alias_hint[i], alias_hint[j],
                               no_alias, sep[i][j]))
                    blocked[i] = 1'b1;
    end
endmodule

// File: rtl/mem_order_slot.sv
module mem_order_slot
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  alloc_onehot,
    input  logic [2:0]        alloc_kind,
    input  logic              alloc_alias,
    input  logic [DEPTH-1:0]  busy,
    input  logic              exec_hit,
    input  logic              blocked,
    output slot_state_e       state_o,
    output logic [2:0]        kind_o,
    output logic              alias_o,
    output logic [DEPTH-1:0]  older_o
);
    localparam logic [DEPTH-1:0] SELF_BIT = DEPTH'(1) << IDX;

    slot_state_e      state_q, state_d;
    logic [2:0]       kind_q;
    logic             alias_q;
    logic [DEPTH-1:0] older_q;
    logic             alloc_hit;

    assign alloc_hit = alloc_onehot[IDX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc_hit) state_d = SLOT_WAIT;
            SLOT_WAIT:  if (!blocked) state_d = SLOT_READY;
            SLOT_READY: if (exec_hit || op_is_barrier(kind_q)) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            alias_q <= 1'b0;
            older_q <= '0;
        end else if (alloc_hit) begin
            kind_q  <= alloc_kind;
            alias_q <= alloc_alias;
            older_q <= busy & ~SELF_BIT;
        end else begin
            older_q <= older_q & ~alloc_onehot;
        end
    end

    assign state_o = state_q;
    assign kind_o  = kind_q;
    assign alias_o = alias_q;
    assign older_o = older_q;

    AST_ALLOC_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_hit |-> state_q == SLOT_FREE) else $error("alloc on busy slot"); // R1
    AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && blocked) |=> state_q == SLOT_WAIT) else $error("blocked op left WAIT"); // R3
    AST_BARRIER_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_READY && op_is_barrier(kind_q)) |-> (older_q & busy) == '0) else $error("barrier ready with older op"); // R6
    AST_BARRIER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_READY && op_is_barrier(kind_q)) |=> state_q == SLOT_FREE) else $error("barrier lingered"); // R6
    AST_EXEC_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_READY && exec_hit) |=> state_q == SLOT_FREE) else $error("exec did not free"); // R8
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned LD_CAP = 0,
    parameter int unsigned ST_CAP = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     no_alias_i,
    input  logic                     alloc_valid_i,
    input  logic [2:0]               alloc_kind_i,
    input  logic                     alloc_alias_i,
    input  logic                     exec_valid_i,
    input  logic [$clog2(DEPTH)-1:0] exec_slot_i,
    output logic [$clog2(DEPTH)-1:0] alloc_slot_o,
    output logic [DEPTH-1:0]         ready_o,
    output logic                     full_o,
    output logic                     load_full_o,
    output logic                     store_full_o
);
    logic [DEPTH-1:0]            busy, alias_vec, blocked, alloc_onehot;
    logic [DEPTH-1:0][2:0]       kinds;
    logic [DEPTH-1:0][DEPTH-1:0] older;
    slot_state_e                 states [DEPTH];

    mem_order_alloc #(.DEPTH(DEPTH), .LD_CAP(LD_CAP), .ST_CAP(ST_CAP)) u_alloc (
        .clk(clk), .rst_n(rst_n), .busy(busy), .kinds(kinds),
        .alloc_valid(alloc_valid_i), .alloc_kind(alloc_kind_i),
        .alloc_slot(alloc_slot_o), .alloc_onehot(alloc_onehot),
        .full(full_o), .load_full(load_full_o), .store_full(store_full_o)
    );

    mem_order_hazard #(.DEPTH(DEPTH)) u_hazard (
        .busy(busy), .kinds(kinds), .alias_hint(alias_vec), .older(older),
        .no_alias(no_alias_i), .blocked(blocked)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        mem_order_slot #(.DEPTH(DEPTH), .IDX(g)) u_slot (
            .clk(clk), .rst_n(rst_n), .alloc_onehot(alloc_onehot),
            .alloc_kind(alloc_kind_i), .alloc_alias(alloc_alias_i), .busy(busy),
            .exec_hit(exec_valid_i && exec_slot_i == g), .blocked(blocked[g]),
            .state_o(states[g]), .kind_o(kinds[g]), .alias_o(alias_vec[g]),
            .older_o(older[g])
        );
        assign busy[g]    = (states[g] != SLOT_FREE);
        assign ready_o[g] = (states[g] == SLOT_READY);
    end

    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> alloc_onehot == '0) else $error("alloc while full"); // R9
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_onehot)) else $error("multiple slots allocated"); // R1
endmodule

// File: tb/test_mem_order_queue.sv
module test_mem_order_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int LD_CAP = 2;
    localparam int ST_CAP = 0;
    localparam int SW     = $clog2(DEPTH);
    localparam int LDE    = (LD_CAP == 0) ? DEPTH : LD_CAP;
    localparam int STE    = (ST_CAP == 0) ? DEPTH : ST_CAP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic no_alias = 1'b1, alloc_valid = 1'b0, alloc_alias = 1'b0, exec_valid = 1'b0;
    logic [2:0] alloc_kind = 3'd0;
    logic [SW-1:0] exec_slot = '0, alloc_slot;
    logic [DEPTH-1:0] ready;
    logic full, load_full, store_full;

    int n_cmp = 0, n_bad = 0, seq = 0;
    int m_st [DEPTH];
    int m_kd [DEPTH];
    int m_age[DEPTH];
    bit m_al [DEPTH];
    bit done = 0;

    mem_order_queue #(.DEPTH(DEPTH), .LD_CAP(LD_CAP), .ST_CAP(ST_CAP)) i_mem_order_queue (
        .clk(clk), .rst_n(rst_n), .no_alias_i(no_alias), .alloc_valid_i(alloc_valid),
        .alloc_kind_i(alloc_kind), .alloc_alias_i(alloc_alias), .exec_valid_i(exec_valid),
        .exec_slot_i(exec_slot), .alloc_slot_o(alloc_slot), .ready_o(ready),
        .full_o(full), .load_full_o(load_full), .store_full_o(store_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_holds(int i, int j);
        bit sep = 0;
        for (int k = 0; k < DEPTH; k++)
            if (m_st[k] != 0 && m_age[k] > m_age[j] && m_age[k] < m_age[i] && m_kd[k] != 0)
                sep = 1;
        if (m_kd[i] == 0) begin
            if (m_kd[j] == 0) return sep;
            if (m_kd[j] == 1) return !no_alias && (m_al[i] || m_al[j]);
            if (m_kd[j] == 3) return 0;
            return 1;
        end
        if (m_kd[i] == 1) return m_kd[j] != 2;
        return 1;
    endfunction

    function automatic bit m_blocked(int i);
        for (int j = 0; j < DEPTH; j++)
            if (j != i && m_st[j] != 0 && m_age[j] < m_age[i] && m_holds(i, j)) return 1;
        return 0;
    endfunction

    task automatic cycle(bit av, int kind, bit al, bit ev, int es);
        int n_st[DEPTH];
        int lf, nld, nst, nbusy;
        bit acc, capok;
        string tg;
        alloc_valid = av; alloc_kind = kind[2:0]; alloc_alias = al;
        exec_valid = ev; exec_slot = es[SW-1:0];
        #1;
        lf = -1; nld = 0; nst = 0; nbusy = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_st[i] == 0) lf = i;
            else begin
                nbusy++;
                if (m_kd[i] == 0) nld++;
                if (m_kd[i] == 1) nst++;
            end
        end
        chk("R1 alloc_slot", alloc_slot, (lf < 0) ? 0 : lf);
        chk("R9 full", full, nbusy == DEPTH);
        chk("R10 load_full", load_full, nld >= LDE);
        chk("R10 store_full", store_full, nst >= STE);
        for (int i = 0; i < DEPTH; i++) begin
            tg = (m_st[i] == 0) ? "R8 ready(free)" : (m_kd[i] == 0) ? "R3 ready(load)" :
                 (m_kd[i] == 1) ? "R5 ready(store)" : "R6 ready(barrier)";
            chk(tg, ready[i], m_st[i] == 2);
        end
        for (int i = 0; i < DEPTH; i++) begin
            n_st[i] = m_st[i];
            if (m_st[i] == 2 && (m_kd[i] >= 2 || (ev && es == i))) n_st[i] = 0;
            if (m_st[i] == 1 && !m_blocked(i)) n_st[i] = 2;
        end
        capok = (kind == 0) ? (nld < LDE) : (kind == 1) ? (nst < STE) : 1;
        acc = av && lf >= 0 && kind <= 4 && capok;
        if (acc) begin
            n_st[lf] = 1; m_kd[lf] = kind; m_al[lf] = al; m_age[lf] = seq; seq++;
        end
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) m_st[i] = n_st[i];
        @(negedge clk);
    endtask

    task automatic idle(); cycle(0, 0, 0, 0, 0); endtask
    task automatic put(int kind, bit al); cycle(1, kind, al, 0, 0); endtask
    task automatic ex(int s); cycle(0, 0, 0, 1, s); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_st[i] = 0; m_kd[i] = 0; m_al[i] = 0; m_age[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset full", {full, load_full, store_full}, 0);
        chk("R1 reset slot", alloc_slot, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: aliasing load behind store, then alias setting flipped
        no_alias = 0;
        put(1, 0);
        chk("R2 wait after alloc", ready, 4'b0000);
        put(0, 1);
        idle();
        chk("R4 alias load held", ready, 4'b0001);
        no_alias = 1;
        idle();
        chk("R4 no_alias releases load", ready, 4'b0011);
        ex(0); ex(1);
        chk("R8 exec frees", ready, 4'b0000);
        no_alias = 0;
        put(1, 0); put(0, 0); idle();
        chk("R4 non-aliasing pair passes", ready, 4'b0011);
        ex(0); ex(1);
        no_alias = 1;

        // R3 / R5: load, store, load
        put(0, 0); put(1, 0); put(0, 0); idle(); idle();
        chk("R3 load held by separated load", ready, 4'b0001);
        ex(2);
        ex(0);
        chk("R8 exec on wait ignored", ready, 4'b0000);
        idle();
        chk("R5 store after load frees", ready, 4'b0110);
        ex(1); ex(2);
        put(0, 0); put(0, 0); idle();
        chk("R3 adjacent loads pass", ready, 4'b0011);
        ex(0); ex(1);

        // R7 / R6 / R9: store, load barrier, store, load
        put(1, 0); put(2, 0); put(1, 0); put(0, 0); idle();
        chk("R7 load barrier order", ready, 4'b0001);
        chk("R9 full flag", full, 1);
        put(0, 0);
        chk("R9 dropped when full", ready, 4'b0001);
        cycle(1, 0, 0, 1, 0);
        chk("R8 freed slot not reused", ready, 4'b0000);
        chk("R8 freed slot offered", alloc_slot, 0);
        idle();
        chk("R7 load barrier passes store", ready, 4'b0110);
        idle();
        chk("R6 barrier self frees", ready, 4'b0100);
        idle();
        chk("R7 load after barrier done", ready, 4'b1100);
        ex(2); ex(3);

        // R7: store barrier does not hold a load
        put(1, 0); put(3, 0); put(0, 0); idle();
        chk("R7 store barrier passes load", ready, 4'b0101);
        ex(0); idle(); idle(); ex(2);
        chk("R6 drained", ready, 4'b0000);

        // R10: limits
        put(0, 0); put(0, 0);
        chk("R10 load limit flag", load_full, 1);
        put(0, 0);
        chk("R10 third load dropped", alloc_slot, 2);
        put(1, 0); put(1, 0);
        chk("R10 store limit zero means depth", store_full, 0);
        ex(0); ex(1); idle(); ex(2); idle(); ex(3);
        for (int i = 0; i < DEPTH; i++) put(1, 0);
        chk("R10 store limit flag", store_full, 1);
        for (int i = 0; i < DEPTH; i++) begin idle(); ex(i); end

        // R11: illegal code
        put(5, 0); idle();
        chk("R11 illegal kind dropped", {ready, full, alloc_slot}, 0);

        // mixed traffic, model compared every cycle
        for (int c = 0; c < 3000; c++) begin
            if (c % 64 == 0) no_alias = $urandom_range(0, 1);
            cycle($urandom_range(0, 2) != 0, $urandom_range(0, 5), $urandom_range(0, 1),
                  $urandom_range(0, 4) < 3, $urandom_range(0, DEPTH - 1));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule